// File: doc/BRIEF.md
# Phase-Reversal Start-Stop Character Receiver

This block takes a squared carrier that is binary phase modulated and recovers the characters it carries. The carrier input is brought into the local clock domain through a synchronizer. Every carrier edge is timed in local clocks, and each half-period is compared with a running nominal value. A half-period that lies well outside the nominal marks a 180-degree phase reversal, and each reversal flips a recovered logic level. Bit windows are counted in carrier half-cycles rather than with a baud timer. Each bit spans sixteen whole carrier cycles, and the logic level is sampled at the centre of the window.

The recovered bit stream is deframed as asynchronous characters. A character is a start bit, eight data bits sent least significant first, an even-parity bit and one stop bit. A character that passes both checks is delivered with a one-cycle valid strobe. A bad parity or a low stop bit raises the matching error flag instead, and the byte is dropped. The link is half-duplex, so an enable input shuts the receiver off while a reply is being sent. If carrier edges stop for a set number of local clocks, the receiver drops back to acquisition.

Top module: `bpsk_frame_rx`

## Requirements
- R1: While reset is held and after it is released, with no carrier edges, `rxValid`, `parityErr` and `frameErr` are 0 and `rxData` is 0x00.
- R2: After lock, a carrier half-period longer than 1.25 times, or shorter than 0.75 times, the tracked nominal half-period is treated as a phase reversal and toggles the recovered level. An in-band half-period replaces the nominal, so a slow change of carrier rate of up to 20 percent between edges is followed.
- R3: Lock is taken on the second carrier edge after acquisition starts, with the recovered level set to 1 (idle). A reversal half-period counts as two half-cycles. Each bit window spans 32 half-cycles (16 carrier cycles), and its value is sampled where the window count passes 16.
- R4: A character is start (0), eight data bits with the least significant first, a parity bit and a stop bit (1). A good character gives `rxValid` high for exactly one cycle, with `rxData` holding the byte.
- R5: Parity is even over the 8 data bits plus the parity bit. If that total is odd and the stop bit is 1, `parityErr` pulses for one cycle, `rxValid` stays low and `rxData` keeps its previous value.
- R6: A stop bit sampled as 0 pulses `frameErr` for one cycle. No `rxValid` or `parityErr` is raised and `rxData` keeps its previous value. At most one of the three strobes is high in any cycle.
- R7: While `rxEnable` is low, carrier edges are ignored and the receiver is unlocked. A character sent, or partly sent, while it is low produces no strobe. After it goes high again, reception resumes after fresh acquisition.
- R8: If no carrier edge is seen for 64 local clocks, the receiver unlocks and abandons any character in progress. A later character is received after re-acquisition.
- R9: Characters sent back to back, with the next start reversal right at the end of the previous stop bit, are each delivered.
- R10: If the start bit is sampled as 1 at its window centre, it is treated as a false start and ignored. A following good character is still received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| carrierIn | input | 1 | Squared phase-modulated carrier, asynchronous to clk |
| rxEnable | input | 1 | High to receive; low while the half-duplex link transmits |
| rxData | output | 8 | Last byte delivered without error |
| rxValid | output | 1 | One-cycle strobe: a new byte is on rxData |
| parityErr | output | 1 | One-cycle strobe: character dropped for odd parity |
| frameErr | output | 1 | One-cycle strobe: character dropped for a low stop bit |

## Verification
A wrong nominal half-period or a missed reversal shows up within one bit window. The recovered level is then inverted from that bit onward, so the delivered byte is wrong, or the parity flag fires, within the same character. A bit window counter that is off by one or two half-cycles shifts the sampling point; at the carrier rates used, this corrupts a data bit or the stop bit and shows as `frameErr` or a wrong `rxData` before the next character begins. A lock or state that is not cleared by disabling or by carrier loss shows as a spurious strobe or a lost first character after re-acquisition.

// File: rtl/bpsk_rx_pkg.sv
package bpsk_rx_pkg;

  // Strobes issued by the control FSM to the datapath
  typedef struct packed {
    logic winStart;   // a start reversal was accepted: realign the bit window
    logic shiftIn;    // capture the recovered level into the character register
    logic finish;     // character complete: judge it and drive the outputs
  } rxCtl_t;

  // Status returned by the datapath to the control FSM
  typedef struct packed {
    logic locked;     // nominal half-period is valid
    logic reversal;   // this cycle carries an edge that ends a reversal half-period
    logic lineVal;    // recovered logic level before this cycle's update
    logic centreTick; // the bit window count passes its centre on this edge
  } rxStat_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_DONE = 2'd2
  } rxState_e;

endpackage

// File: rtl/bpsk_rx_datapath.sv
module bpsk_rx_datapath
  import bpsk_rx_pkg::*;
#(
  parameter int CYCLES_PER_BIT = 16,
  parameter int DATA_BITS      = 8,
  parameter int LOSS_CLKS      = 64,
  parameter int SYNC_STAGES    = 2   // at least 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 carrierIn,
  input  logic                 rxEnable,
  input  rxCtl_t               ctl,
  output rxStat_t              stat,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxValid,
  output logic                 parityErr,
  output logic                 frameErr
);

  localparam int HALVES_PER_BIT = 2 * CYCLES_PER_BIT;
  localparam int CENTRE         = CYCLES_PER_BIT;
  localparam int POS_W          = $clog2(HALVES_PER_BIT) + 1;
  localparam int CNT_W          = $clog2(LOSS_CLKS + 1);
  localparam int CMP_W          = CNT_W + 3;
  localparam int FRAME_SHIFT    = DATA_BITS + 2;   // data, parity, stop

  // ---------------- carrier synchronizer and edge detect ----------------
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   cPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
      cPrev     <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], carrierIn};
      cPrev     <= syncChain[SYNC_STAGES-1];
    end
  end

  logic edgeSeen;
  assign edgeSeen = rxEnable && (syncChain[SYNC_STAGES-1] ^ cPrev);

  // ---------------- half-period measurement and tracking ----------------
  logic [CNT_W-1:0] halfLen;
  logic [CNT_W-1:0] nominal;
  logic             armed;
  logic             locked;
  logic             lineVal;
  logic [POS_W-1:0] winPos;

  logic [CMP_W-1:0] meas4, nom5, nom3;
  logic             isLong, isShort;

  assign meas4   = CMP_W'({halfLen, 2'b00});
  assign nom5    = CMP_W'({nominal, 2'b00}) + CMP_W'(nominal);
  assign nom3    = CMP_W'({nominal, 1'b0}) + CMP_W'(nominal);
  assign isLong  = meas4 > nom5;
  assign isShort = meas4 < nom3;

  logic [POS_W-1:0] posSum, nextPos;
  assign posSum  = winPos + (isLong ? POS_W'(2) : POS_W'(1));
  assign nextPos = (posSum >= POS_W'(HALVES_PER_BIT)) ? posSum - POS_W'(HALVES_PER_BIT) : posSum;

  logic carrierLost;
  assign carrierLost = (halfLen == CNT_W'(LOSS_CLKS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfLen <= CNT_W'(1);
      nominal <= '0;
      armed   <= 1'b0;
      locked  <= 1'b0;
      lineVal <= 1'b1;
      winPos  <= '0;
    end else if (!rxEnable) begin
      halfLen <= CNT_W'(1);
      armed   <= 1'b0;
      locked  <= 1'b0;
    end else if (edgeSeen) begin
      halfLen <= CNT_W'(1);
      if (!armed) begin
        armed <= 1'b1;
      end else if (!locked) begin
        locked  <= 1'b1;
        nominal <= halfLen;
        lineVal <= 1'b1;
        winPos  <= '0;
      end else begin
        if (isLong || isShort) lineVal <= ~lineVal;
        else                   nominal <= halfLen;
        winPos <= ctl.winStart ? POS_W'(1) : nextPos;
      end
    end else if (carrierLost) begin
      armed  <= 1'b0;
      locked <= 1'b0;
    end else begin
      halfLen <= halfLen + CNT_W'(1);
    end
  end

  assign stat.locked     = locked;
  assign stat.lineVal    = lineVal;
  assign stat.reversal   = edgeSeen && locked && (isLong || isShort);
  assign stat.centreTick = edgeSeen && locked &&
                           (winPos < POS_W'(CENTRE)) && (posSum >= POS_W'(CENTRE));

  // ---------------- character register and result ----------------
  logic [FRAME_SHIFT-1:0] charReg;
  logic                   stopBit, parityOdd;

  assign stopBit   = charReg[FRAME_SHIFT-1];
  assign parityOdd = ^charReg[DATA_BITS:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      charReg   <= '0;
      rxData    <= '0;
      rxValid   <= 1'b0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
    end else begin
      rxValid   <= 1'b0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
      if (ctl.shiftIn) charReg <= {lineVal, charReg[FRAME_SHIFT-1:1]};
      if (ctl.finish) begin
        if (!stopBit)       frameErr  <= 1'b1;
        else if (parityOdd) parityErr <= 1'b1;
        else begin
          rxValid <= 1'b1;
          rxData  <= charReg[DATA_BITS-1:0];
        end
      end
    end
  end

endmodule

// File: rtl/bpsk_rx_ctrl.sv
module bpsk_rx_ctrl
  import bpsk_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  rxStat_t stat,
  output rxCtl_t  ctl
);

  localparam int FRAME_BITS = DATA_BITS + 3;   // start, data, parity, stop
  localparam int IDX_W      = $clog2(FRAME_BITS + 1);

  rxState_e         state;
  logic [IDX_W-1:0] bitIdx;

  always_comb begin
    ctl.winStart = (state == ST_IDLE) && stat.reversal && stat.lineVal;
    ctl.shiftIn  = (state == ST_RECV) && stat.centreTick && (bitIdx != '0);
    ctl.finish   = (state == ST_DONE) && stat.locked;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitIdx <= '0;
    end else if (!stat.locked) begin
      state  <= ST_IDLE;
      bitIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          bitIdx <= '0;
          if (ctl.winStart) state <= ST_RECV;
        end
        ST_RECV: begin
          if (stat.centreTick) begin
            if (bitIdx == '0) begin
              if (stat.lineVal) state <= ST_IDLE;   // false start
              else bitIdx <= IDX_W'(1);
            end else if (bitIdx == IDX_W'(FRAME_BITS - 1)) begin
              state <= ST_DONE;
            end else begin
              bitIdx <= bitIdx + IDX_W'(1);
            end
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bpsk_frame_rx.sv
module bpsk_frame_rx
  import bpsk_rx_pkg::*;
#(
  parameter int CYCLES_PER_BIT = 16,
  parameter int DATA_BITS      = 8,
  parameter int LOSS_CLKS      = 64,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 carrierIn,
  input  logic                 rxEnable,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxValid,
  output logic                 parityErr,
  output logic                 frameErr
);

  rxCtl_t  ctl;
  rxStat_t stat;

  bpsk_rx_datapath #(
    .CYCLES_PER_BIT(CYCLES_PER_BIT),
    .DATA_BITS     (DATA_BITS),
    .LOSS_CLKS     (LOSS_CLKS),
    .SYNC_STAGES   (SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .carrierIn(carrierIn),
    .rxEnable (rxEnable),
    .ctl      (ctl),
    .stat     (stat),
    .rxData   (rxData),
    .rxValid  (rxValid),
    .parityErr(parityErr),
    .frameErr (frameErr)
  );

  bpsk_rx_ctrl #(
    .DATA_BITS(DATA_BITS)
  ) u_ctrl (
    .clk (clk),
    .rstN(rstN),
    .stat(stat),
    .ctl (ctl)
  );

endmodule

// File: rtl/bpsk_frame_rx_chk.sv
module bpsk_frame_rx_chk #(
  parameter int DATA_BITS = 8,
  parameter int LOSS_CLKS = 64
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 carrierIn,
  input logic                 rxEnable,
  input logic [DATA_BITS-1:0] rxData,
  input logic                 rxValid,
  input logic                 parityErr,
  input logic                 frameErr
);

  localparam int QUIET_LIMIT = LOSS_CLKS + 4;
  localparam int QC_W        = $clog2(QUIET_LIMIT + 1) + 1;

  logic            inPrev;
  logic [QC_W-1:0] quietCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inPrev   <= 1'b0;
      quietCnt <= '0;
    end else begin
      inPrev <= carrierIn;
      if (carrierIn != inPrev)                quietCnt <= '0;
      else if (quietCnt < QC_W'(QUIET_LIMIT)) quietCnt <= quietCnt + QC_W'(1);
    end
  end

  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    $countones({rxValid, parityErr, frameErr}) <= 1);

  assert_data_only_on_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rxData != $past(rxData)) |-> rxValid);

  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable && $past(!rxEnable) && $past(!rxEnable, 2)) |-> !(rxValid || parityErr || frameErr));

  assert_loss_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (quietCnt >= QC_W'(QUIET_LIMIT)) |-> !(rxValid || parityErr || frameErr));

endmodule

bind bpsk_frame_rx bpsk_frame_rx_chk #(
  .DATA_BITS(DATA_BITS),
  .LOSS_CLKS(LOSS_CLKS)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .carrierIn(carrierIn),
  .rxEnable (rxEnable),
  .rxData   (rxData),
  .rxValid  (rxValid),
  .parityErr(parityErr),
  .frameErr (frameErr)
);

// File: tb/bpsk_frame_rx_tb.sv
module bpsk_frame_rx_tb;

  localparam int CYC = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       carrierIn = 1'b0;
  logic       rxEnable = 1'b1;
  logic [7:0] rxData;
  logic       rxValid, parityErr, frameErr;

  int   errors = 0;
  int   checks = 0;
  int   H = 10;          // local clocks per carrier half-period
  logic lineBit = 1'b1;  // level the bench is currently sending
  bit   done = 1'b0;

  int         validCnt = 0, perrCnt = 0, ferrCnt = 0;
  logic [7:0] lastData = 8'h00, prevData = 8'h00;

  always #5 clk = ~clk;

  bpsk_frame_rx u_dut (
    .clk(clk), .rstN(rstN), .carrierIn(carrierIn), .rxEnable(rxEnable),
    .rxData(rxData), .rxValid(rxValid), .parityErr(parityErr), .frameErr(frameErr)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (rxValid) begin
        validCnt <= validCnt + 1;
        prevData <= lastData;
        lastData <= rxData;
      end
      if (parityErr) perrCnt <= perrCnt + 1;
      if (frameErr)  ferrCnt <= ferrCnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic halfPeriod(input bit doToggle);
    if (doToggle) carrierIn = ~carrierIn;
    waitClk(H);
  endtask

  task automatic idleHalves(input int n);
    for (int i = 0; i < n; i++) halfPeriod(1'b1);
  endtask

  task automatic sendBit(input bit b);
    for (int h = 0; h < 2 * CYC; h++) halfPeriod(!(h == 0 && b != lineBit));
    lineBit = b;
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit badPar, input bit stopV);
    sendBit(1'b0);
    for (int i = 0; i < 8; i++) sendBit(d[i]);
    sendBit((^d) ^ badPar);
    sendBit(stopV);
  endtask

  task automatic acquire();
    lineBit = 1'b1;
    idleHalves(24);
  endtask

  task automatic expectDelta(input string req, input int v0, input int p0, input int f0,
                             input int dv, input int dp, input int df);
    check(validCnt - v0 == dv, {req, " valid count"}, validCnt - v0, dv);
    check(perrCnt - p0 == dp, {req, " parity count"}, perrCnt - p0, dp);
    check(ferrCnt - f0 == df, {req, " framing count"}, ferrCnt - f0, df);
  endtask

  task automatic testReset();
    waitClk(2);
    check({rxValid, parityErr, frameErr} == 3'b000, "R1 strobes in reset", {rxValid, parityErr, frameErr}, 0);
    check(rxData == 8'h00, "R1 data in reset", rxData, 0);
    rstN = 1'b1;
    waitClk(5);
    check({rxValid, parityErr, frameErr} == 3'b000, "R1 strobes after reset", {rxValid, parityErr, frameErr}, 0);
    check(rxData == 8'h00, "R1 data after reset", rxData, 0);
  endtask

  task automatic testGoodFrame(input logic [7:0] d);
    int v0 = validCnt, p0 = perrCnt, f0 = ferrCnt;
    sendFrame(d, 1'b0, 1'b1);
    idleHalves(4);
    expectDelta("R4", v0, p0, f0, 1, 0, 0);
    check(lastData == d, "R3 R4 received byte", lastData, d);
    check(rxData == d, "R4 rxData holds byte", rxData, d);
  endtask

  task automatic testParity();
    int v0 = validCnt, p0 = perrCnt, f0 = ferrCnt;
    logic [7:0] held = rxData;
    sendFrame(8'h5A, 1'b1, 1'b1);
    idleHalves(4);
    expectDelta("R5", v0, p0, f0, 0, 1, 0);
    check(rxData == held, "R5 rxData unchanged", rxData, held);
  endtask

  task automatic testFraming();
    int v0 = validCnt, p0 = perrCnt, f0 = ferrCnt;
    logic [7:0] held = rxData;
    sendFrame(8'h77, 1'b0, 1'b0);
    sendBit(1'b1);
    idleHalves(4);
    expectDelta("R6", v0, p0, f0, 0, 0, 1);
    check(rxData == held, "R6 rxData unchanged", rxData, held);
  endtask

  task automatic testRateChange();
    waitClk(100);          // drop lock, then re-acquire at a new rate
    H = 6;
    acquire();
    testGoodFrame(8'hE1);  // R2 R8
    H = 10;
    waitClk(100);
    acquire();
  endtask

  task automatic testDrift();
    int v0 = validCnt;
    H = 12;                // 20 percent step from the locked nominal
    sendFrame(8'h96, 1'b0, 1'b1);
    idleHalves(4);
    check(validCnt - v0 == 1, "R2 drift frame delivered", validCnt - v0, 1);
    check(lastData == 8'h96, "R2 drift byte", lastData, 8'h96);
    H = 10;
    idleHalves(6);
  endtask

  task automatic testDisableMid();
    int v0 = validCnt, p0 = perrCnt, f0 = ferrCnt;
    logic [7:0] d = 8'hB4;
    sendBit(1'b0);
    for (int i = 0; i < 4; i++) sendBit(d[i]);
    rxEnable = 1'b0;
    for (int i = 4; i < 8; i++) sendBit(d[i]);
    sendBit(^d);
    sendBit(1'b1);
    idleHalves(4);
    expectDelta("R7 mid-frame disable", v0, p0, f0, 0, 0, 0);
    v0 = validCnt;
    sendFrame(8'h3F, 1'b0, 1'b1);
    idleHalves(4);
    check(validCnt - v0 == 0, "R7 frame while disabled", validCnt - v0, 0);
    rxEnable = 1'b1;
    acquire();
    testGoodFrame(8'h4D);
  endtask

  task automatic testLoss();
    int v0 = validCnt, p0 = perrCnt, f0 = ferrCnt;
    sendBit(1'b0);
    sendBit(1'b1);
    sendBit(1'b0);
    sendBit(1'b1);
    waitClk(80);
    acquire();
    sendFrame(8'h3C, 1'b0, 1'b1);
    idleHalves(4);
    expectDelta("R8", v0, p0, f0, 1, 0, 0);
    check(lastData == 8'h3C, "R8 byte after re-acquire", lastData, 8'h3C);
  endtask

  task automatic testFalseStart();
    int v0 = validCnt, p0 = perrCnt, f0 = ferrCnt;
    halfPeriod(1'b0);      // reversal to 0
    idleHalves(4);
    halfPeriod(1'b0);      // reversal back to 1 before the window centre
    idleHalves(40);
    expectDelta("R10 false start", v0, p0, f0, 0, 0, 0);
    testGoodFrame(8'hC3);
  endtask

  task automatic testBackToBack();
    int v0 = validCnt;
    sendFrame(8'h12, 1'b0, 1'b1);
    sendFrame(8'h34, 1'b0, 1'b1);
    idleHalves(4);
    check(validCnt - v0 == 2, "R9 two frames", validCnt - v0, 2);
    check(prevData == 8'h12, "R9 first byte", prevData, 8'h12);
    check(lastData == 8'h34, "R9 second byte", lastData, 8'h34);
  endtask

  initial begin
    testReset();
    acquire();
    testGoodFrame(8'hA5);
    testGoodFrame(8'h00);
    testGoodFrame(8'hFF);
    testGoodFrame(8'h01);
    testParity();
    testFraming();
    testRateChange();
    testDrift();
    testDisableMid();
    testLoss();
    testFalseStart();
    testBackToBack();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule